// File: doc/BRIEF.md
# Privileged instruction legality checker

This block sits beside the instruction decoder and decides, for each class of privileged or state-dependent instruction, whether executing it now would raise an illegal-instruction fault, a virtual-instruction fault, or neither. It looks only at the current privilege mode (machine, hypervisor-extended supervisor, hypervisor-extended user, virtual supervisor, virtual user) and at a handful of status and configuration fields. The fields are: the trap-on-translation-management and timeout-wait controls with their virtual-mode counterparts, the hypervisor user-access bit, the floating-point and vector unit states, the dynamic rounding mode, and three levels of cache-block operation enables.

The outputs are two flag vectors indexed by instruction class, plus a flag telling the decoder that a cache-block invalidate must be executed as a flush. The decoder picks the bit for the class it has decoded. All flags are registered, so they describe the inputs present at the previous rising clock edge. When both faults apply to one class, only the illegal flag is raised.

Top module: `priv_legality_chk`

## Requirements
- R1: While rst_ni is low, ill_o, virt_o and inv2flush_o are all zero, and they clear as soon as reset asserts.
- R2: Each output reflects the inputs sampled at the previous rising edge of clk_i. mode_i codes: 0 = M, 1 = HS, 2 = HU, 3 = VS, 4 = VU; codes 5 to 7 behave as M. In M mode no virtual flag and no flush flag is raised.
- R3: Translation fence (bit 0) and guest-physical hypervisor fence (bit 1) are illegal in HS with tvm_i set, and in HU. Bit 0 is a virtual fault in VS with vtvm_i set, and in VU. Bit 1 is a virtual fault in VS and in VU.
- R4: Virtual-space hypervisor fence (bit 2) is illegal in HU and a virtual fault in VS and VU.
- R5: Hypervisor load/store (bit 3) is illegal in HU when hu_acc_i is clear and a virtual fault in VS and VU.
- R6: Wait-for-interrupt (bit 4) is illegal in HU, or in any non-M mode with tw_i set. It is a virtual fault in VU with tw_i clear, or in VS with tw_i clear and vtw_i set.
- R7: FP instructions (bit 5) are illegal when fs_i is 00. Vector instructions (bit 6) are illegal when vs_i is 00. Rounding-mode use (bit 7) is illegal when frm_i exceeds 4. These three classes are never virtual faults.
- R8: Cache-block zero (bit 8) uses enable bit 0 of cbo_m_en_i, cbo_s_en_i and cbo_h_en_i. It is illegal outside M when the machine bit is clear, or in HU when the supervisor bit is clear. It is a virtual fault when the machine bit is set and either the mode is VS with the hypervisor bit clear, or the mode is VU with the hypervisor or supervisor bit clear.
- R9: Cache-block clean/flush (bit 9) follows the rule of R8 using enable bit 1 of the same three inputs.
- R10: Cache-block invalidate (bit 10) uses the 2-bit fields inv_m_i, inv_s_i and inv_h_i, where 01 = flush, 11 = invalidate, and 00 or 10 = off. It is illegal outside M with the machine field off, or in HU with the supervisor field off. It is a virtual fault when the machine field is not off and either the mode is VS with the hypervisor field off, or the mode is VU with the hypervisor or supervisor field off.
- R11: inv2flush_o is raised in each of these cases: HS with the machine field at flush; HU with the machine or supervisor field at flush; VS with the machine or hypervisor field at flush; VU with any of the three fields at flush.
- R12: A class never has both flags set; when both conditions hold, only ill_o is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Current privilege mode code |
| tvm_i | input | 1 | Trap translation management from HS |
| tw_i | input | 1 | Timeout-wait control |
| vtvm_i | input | 1 | Trap translation management from VS |
| vtw_i | input | 1 | Timeout-wait control for VS |
| hu_acc_i | input | 1 | HU may use hypervisor loads/stores |
| fs_i | input | 2 | FP unit state, 00 = off |
| vs_i | input | 2 | Vector unit state, 00 = off |
| frm_i | input | 3 | Dynamic rounding mode |
| cbo_m_en_i | input | 2 | Machine cache-block enables, bit 0 zero, bit 1 clean/flush |
| cbo_s_en_i | input | 2 | Supervisor cache-block enables |
| cbo_h_en_i | input | 2 | Hypervisor cache-block enables |
| inv_m_i | input | 2 | Machine invalidate control |
| inv_s_i | input | 2 | Supervisor invalidate control |
| inv_h_i | input | 2 | Hypervisor invalidate control |
| ill_o | output | 11 | Illegal-instruction flag per class |
| virt_o | output | 11 | Virtual-instruction flag per class |
| inv2flush_o | output | 1 | Execute invalidate as flush |

## Verification
The hardest corners are the ones where the cache-block hierarchy and the mode meet: a virtual fault needs the machine level enabled while a lower level is disabled, and an invalidate flush needs the reserved 10 code to count as off rather than flush. The bench reaches these by sweeping all eight mode codes against every combination of the six enable bits and the three 2-bit invalidate fields. Separate sweeps take every mode across all trap and wait controls, and every unit-state and rounding-mode value, while the other fields take random values. A scoreboard compares every class bit with a model built from the requirements.

// File: rtl/priv_legal_pkg.sv
package priv_legal_pkg;
  localparam int unsigned MODE_W = 3;
  localparam int unsigned XS_W   = 2;
  localparam int unsigned FRM_W  = 3;
  localparam int unsigned INV_W  = 2;
  localparam int unsigned N_CBE  = 2;   // enable bit 0 zero, bit 1 clean/flush

  localparam logic [MODE_W-1:0] MODE_M  = 3'd0;
  localparam logic [MODE_W-1:0] MODE_HS = 3'd1;
  localparam logic [MODE_W-1:0] MODE_HU = 3'd2;
  localparam logic [MODE_W-1:0] MODE_VS = 3'd3;
  localparam logic [MODE_W-1:0] MODE_VU = 3'd4;

  localparam logic [XS_W-1:0]  XS_OFF    = 2'b00;
  localparam logic [INV_W-1:0] INV_FLUSH = 2'b01;
  localparam logic [INV_W-1:0] INV_FULL  = 2'b11;

  localparam int unsigned CLS_AT_FENCE = 0;
  localparam int unsigned CLS_HG_FENCE = 1;
  localparam int unsigned CLS_HV_FENCE = 2;
  localparam int unsigned CLS_HLSV     = 3;
  localparam int unsigned CLS_WFI      = 4;
  localparam int unsigned CLS_FP       = 5;
  localparam int unsigned CLS_VEC      = 6;
  localparam int unsigned CLS_FRM      = 7;
  localparam int unsigned CLS_CBO_BASE = 8;
  localparam int unsigned CLS_CBO_INV  = CLS_CBO_BASE + N_CBE;
  localparam int unsigned N_SYS        = 5;
  localparam int unsigned N_CLS        = CLS_CBO_INV + 1;

  typedef struct packed {
    logic m;
    logic hs;
    logic hu;
    logic vs;
    logic vu;
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(logic [MODE_W-1:0] code);
    mode_dec_t d;
    d.hs = (code == MODE_HS);
    d.hu = (code == MODE_HU);
    d.vs = (code == MODE_VS);
    d.vu = (code == MODE_VU);
    d.m  = !(d.hs || d.hu || d.vs || d.vu);  // unused codes act as M
    return d;
  endfunction

  function automatic logic inv_is_off(logic [INV_W-1:0] f);
    return (f != INV_FLUSH) && (f != INV_FULL);
  endfunction

  function automatic logic inv_is_flush(logic [INV_W-1:0] f);
    return f == INV_FLUSH;
  endfunction
endpackage

// File: rtl/plc_sys_rules.sv
module plc_sys_rules
  import priv_legal_pkg::*;
(
  input  mode_dec_t        md_i,
  input  logic             tvm_i,
  input  logic             tw_i,
  input  logic             vtvm_i,
  input  logic             vtw_i,
  input  logic             hu_acc_i,
  output logic [N_SYS-1:0] ill_o,
  output logic [N_SYS-1:0] virt_o
);
  logic tvm_trap;
  assign tvm_trap = (md_i.hs && tvm_i) || md_i.hu;

  always_comb begin
    ill_o  = '0;
    virt_o = '0;
    ill_o [CLS_AT_FENCE] = tvm_trap;
    virt_o[CLS_AT_FENCE] = (md_i.vs && vtvm_i) || md_i.vu;
    ill_o [CLS_HG_FENCE] = tvm_trap;
    virt_o[CLS_HG_FENCE] = md_i.vs || md_i.vu;
    ill_o [CLS_HV_FENCE] = md_i.hu;
    virt_o[CLS_HV_FENCE] = md_i.vs || md_i.vu;
    ill_o [CLS_HLSV]     = md_i.hu && !hu_acc_i;
    virt_o[CLS_HLSV]     = md_i.vs || md_i.vu;
    ill_o [CLS_WFI]      = md_i.hu || (!md_i.m && tw_i);
    virt_o[CLS_WFI]      = !tw_i && (md_i.vu || (md_i.vs && vtw_i));
  end
endmodule

// File: rtl/plc_cbo_enable.sv
module plc_cbo_enable (
  input  logic not_m_i,
  input  logic hu_i,
  input  logic vs_i,
  input  logic vu_i,
  input  logic m_en_i,
  input  logic s_en_i,
  input  logic h_en_i,
  output logic ill_o,
  output logic virt_o
);
  assign ill_o  = (not_m_i && !m_en_i) || (hu_i && !s_en_i);
  assign virt_o = m_en_i && ((vs_i && !h_en_i) || (vu_i && (!h_en_i || !s_en_i)));
endmodule

// File: rtl/plc_cbo_inval.sv
module plc_cbo_inval
  import priv_legal_pkg::*;
(
  input  mode_dec_t        md_i,
  input  logic [INV_W-1:0] m_f_i,
  input  logic [INV_W-1:0] s_f_i,
  input  logic [INV_W-1:0] h_f_i,
  output logic             ill_o,
  output logic             virt_o,
  output logic             flush_o
);
  logic m_off, s_off, h_off, m_fl, s_fl, h_fl;
  assign m_off = inv_is_off(m_f_i);
  assign s_off = inv_is_off(s_f_i);
  assign h_off = inv_is_off(h_f_i);
  assign m_fl  = inv_is_flush(m_f_i);
  assign s_fl  = inv_is_flush(s_f_i);
  assign h_fl  = inv_is_flush(h_f_i);

  assign ill_o   = (!md_i.m && m_off) || (md_i.hu && s_off);
  assign virt_o  = !m_off && ((md_i.vs && h_off) || (md_i.vu && (h_off || s_off)));
  assign flush_o = (md_i.hs && m_fl)
                || (md_i.hu && (m_fl || s_fl))
                || (md_i.vs && (m_fl || h_fl))
                || (md_i.vu && (m_fl || h_fl || s_fl));
endmodule

// File: rtl/priv_legality_chk.sv
module priv_legality_chk
  import priv_legal_pkg::*;
#(
  parameter int unsigned FRM_LIMIT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [MODE_W-1:0]  mode_i,
  input  logic               tvm_i,
  input  logic               tw_i,
  input  logic               vtvm_i,
  input  logic               vtw_i,
  input  logic               hu_acc_i,
  input  logic [XS_W-1:0]    fs_i,
  input  logic [XS_W-1:0]    vs_i,
  input  logic [FRM_W-1:0]   frm_i,
  input  logic [N_CBE-1:0]   cbo_m_en_i,
  input  logic [N_CBE-1:0]   cbo_s_en_i,
  input  logic [N_CBE-1:0]   cbo_h_en_i,
  input  logic [INV_W-1:0]   inv_m_i,
  input  logic [INV_W-1:0]   inv_s_i,
  input  logic [INV_W-1:0]   inv_h_i,
  output logic [N_CLS-1:0]   ill_o,
  output logic [N_CLS-1:0]   virt_o,
  output logic               inv2flush_o
);
  localparam logic [FRM_W-1:0] FRM_MAX = FRM_W'(FRM_LIMIT);

  mode_dec_t        md;
  logic [N_SYS-1:0] sys_ill, sys_virt;
  logic [N_CBE-1:0] cbe_ill, cbe_virt;
  logic             inv_ill, inv_virt, inv_fl;
  logic [N_CLS-1:0] ill_raw, virt_raw;
  logic [N_CLS-1:0] ill_q, virt_q;
  logic             fl_q;

  assign md = decode_mode(mode_i);

  plc_sys_rules i_sys (
    .md_i    (md),
    .tvm_i   (tvm_i),
    .tw_i    (tw_i),
    .vtvm_i  (vtvm_i),
    .vtw_i   (vtw_i),
    .hu_acc_i(hu_acc_i),
    .ill_o   (sys_ill),
    .virt_o  (sys_virt)
  );

  for (genvar g = 0; g < N_CBE; g++) begin : g_cbe
    plc_cbo_enable i_cbe (
      .not_m_i(!md.m),
      .hu_i   (md.hu),
      .vs_i   (md.vs),
      .vu_i   (md.vu),
      .m_en_i (cbo_m_en_i[g]),
      .s_en_i (cbo_s_en_i[g]),
      .h_en_i (cbo_h_en_i[g]),
      .ill_o  (cbe_ill[g]),
      .virt_o (cbe_virt[g])
    );
  end

  plc_cbo_inval i_inv (
    .md_i   (md),
    .m_f_i  (inv_m_i),
    .s_f_i  (inv_s_i),
    .h_f_i  (inv_h_i),
    .ill_o  (inv_ill),
    .virt_o (inv_virt),
    .flush_o(inv_fl)
  );

  always_comb begin
    ill_raw  = '0;
    virt_raw = '0;
    ill_raw [N_SYS-1:0] = sys_ill;
    virt_raw[N_SYS-1:0] = sys_virt;
    ill_raw [CLS_FP]    = (fs_i == XS_OFF);
    ill_raw [CLS_VEC]   = (vs_i == XS_OFF);
    ill_raw [CLS_FRM]   = (frm_i > FRM_MAX);
    ill_raw [CLS_CBO_BASE +: N_CBE] = cbe_ill;
    virt_raw[CLS_CBO_BASE +: N_CBE] = cbe_virt;
    ill_raw [CLS_CBO_INV] = inv_ill;
    virt_raw[CLS_CBO_INV] = inv_virt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ill_q  <= '0;
      virt_q <= '0;
      fl_q   <= 1'b0;
    end else begin
      ill_q  <= ill_raw;
      virt_q <= virt_raw & ~ill_raw;  // illegal wins over virtual
      fl_q   <= inv_fl;
    end
  end

  assign ill_o       = ill_q;
  assign virt_o      = virt_q;
  assign inv2flush_o = fl_q;

  // R2
  m_no_virt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_M) |=> (virt_o == '0 && !inv2flush_o));
  // R7
  fp_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_i == XS_OFF) |=> ill_o[CLS_FP]);
  // R7
  frm_rsv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_i > FRM_MAX) |=> ill_o[CLS_FRM]);
  // R6
  wfi_vu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_VU && !tw_i) |=> virt_o[CLS_WFI]);
  // R5
  hlsv_hu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_HU && !hu_acc_i) |=> ill_o[CLS_HLSV]);
endmodule

// File: tb/test_priv_legality_chk.sv
`timescale 1ns/1ps
module test_priv_legality_chk;
  localparam int NC = 11;

  typedef struct packed {
    logic [2:0] mode;
    logic       tvm, tw, vtvm, vtw, hu_acc;
    logic [1:0] fs, vs;
    logic [2:0] frm;
    logic [1:0] men, sen, hen;
    logic [1:0] im, is, ih;
  } stim_t;

  typedef struct packed {
    logic [NC-1:0] ill;
    logic [NC-1:0] virt;
    logic          fl;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  stim_t st = '0;
  logic [NC-1:0] ill_o, virt_o;
  logic inv2flush_o;
  exp_t q[$];
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  priv_legality_chk i_priv_legality_chk (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(st.mode),
    .tvm_i(st.tvm), .tw_i(st.tw), .vtvm_i(st.vtvm), .vtw_i(st.vtw),
    .hu_acc_i(st.hu_acc), .fs_i(st.fs), .vs_i(st.vs), .frm_i(st.frm),
    .cbo_m_en_i(st.men), .cbo_s_en_i(st.sen), .cbo_h_en_i(st.hen),
    .inv_m_i(st.im), .inv_s_i(st.is), .inv_h_i(st.ih),
    .ill_o(ill_o), .virt_o(virt_o), .inv2flush_o(inv2flush_o)
  );

  function automatic logic off2(logic [1:0] f);
    return f == 2'b00 || f == 2'b10;
  endfunction

  // Reference built from the requirement text
  function automatic exp_t ref_model(stim_t s);
    exp_t e;
    logic hs, hu, vsm, vu, m;
    hs = s.mode == 3'd1; hu = s.mode == 3'd2;
    vsm = s.mode == 3'd3; vu = s.mode == 3'd4;
    m = !(hs || hu || vsm || vu);                              // R2
    e = '0;
    e.ill[0] = (hs && s.tvm) || hu;                            // R3
    e.virt[0] = (vsm && s.vtvm) || vu;
    e.ill[1] = (hs && s.tvm) || hu;
    e.virt[1] = vsm || vu;
    e.ill[2] = hu; e.virt[2] = vsm || vu;                      // R4
    e.ill[3] = hu && !s.hu_acc; e.virt[3] = vsm || vu;         // R5
    e.ill[4] = hu || (!m && s.tw);                             // R6
    e.virt[4] = (vu && !s.tw) || (vsm && !s.tw && s.vtw);
    e.ill[5] = s.fs == 2'b00;                                  // R7
    e.ill[6] = s.vs == 2'b00;
    e.ill[7] = s.frm > 3'd4;
    for (int k = 0; k < 2; k++) begin                          // R8 R9
      e.ill[8+k] = (!m && !s.men[k]) || (hu && !s.sen[k]);
      e.virt[8+k] = s.men[k] && ((vsm && !s.hen[k]) || (vu && (!s.hen[k] || !s.sen[k])));
    end
    e.ill[10] = (!m && off2(s.im)) || (hu && off2(s.is));      // R10
    e.virt[10] = !off2(s.im) && ((vsm && off2(s.ih)) || (vu && (off2(s.ih) || off2(s.is))));
    e.fl = (hs && s.im == 2'b01)                               // R11
        || (hu && (s.im == 2'b01 || s.is == 2'b01))
        || (vsm && (s.im == 2'b01 || s.ih == 2'b01))
        || (vu && (s.im == 2'b01 || s.ih == 2'b01 || s.is == 2'b01));
    e.virt = e.virt & ~e.ill;                                  // R12
    return e;
  endfunction

  function automatic string cls_req(int c);
    case (c)
      0, 1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5, 6, 7: return "R7";
      8: return "R8";
      9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(stim_t s);
    @(negedge clk);
    st = s;
    q.push_back(ref_model(s));
  endtask

  function automatic stim_t rnd_stim();
    stim_t s;
    s = stim_t'({$urandom, $urandom});
    return s;
  endfunction

  // Monitor: outputs one edge after the drive (R2 timing)
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        for (int c = 0; c < NC; c++) begin
          n_chk += 2;
          if (ill_o[c] !== e.ill[c]) begin
            n_fail++;
            $display("FAIL %s/R2 ill class %0d mode %0d: got %b exp %b",
                     cls_req(c), c, st.mode, ill_o[c], e.ill[c]);
          end
          if (virt_o[c] !== e.virt[c]) begin
            n_fail++;
            $display("FAIL %s/R12 virt class %0d: got %b exp %b",
                     cls_req(c), c, virt_o[c], e.virt[c]);
          end
        end
        n_chk++;
        if (inv2flush_o !== e.fl) begin
          n_fail++;
          $display("FAIL R11 inv2flush: got %b exp %b", inv2flush_o, e.fl);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    stim_t s;
    // R1: reset holds flags clear even with faulting inputs
    st = '0;
    st.mode = 3'd2;
    repeat (3) @(negedge clk);
    n_chk++;
    if (ill_o !== '0 || virt_o !== '0 || inv2flush_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: got %h/%h/%b exp 0/0/0", ill_o, virt_o, inv2flush_o);
    end
    rst_ni = 1'b1;

    // R3 R4 R5 R6: every mode code against all trap/wait controls
    for (int md = 0; md < 8; md++)
      for (int b = 0; b < 32; b++) begin
        s = rnd_stim();
        s.mode = 3'(md);
        {s.tvm, s.tw, s.vtvm, s.vtw, s.hu_acc} = 5'(b);
        apply(s);
      end

    // R7: unit states and rounding modes
    for (int f = 0; f < 4; f++)
      for (int v = 0; v < 4; v++)
        for (int r = 0; r < 8; r++) begin
          s = rnd_stim();
          s.fs = 2'(f); s.vs = 2'(v); s.frm = 3'(r);
          apply(s);
        end

    // R8 R9 R10 R11: cache-block hierarchy sweep
    for (int md = 0; md < 8; md++)
      for (int en = 0; en < 64; en++)
        for (int iv = 0; iv < 64; iv++) begin
          s = rnd_stim();
          s.mode = 3'(md);
          {s.men, s.sen, s.hen} = 6'(en);
          {s.im, s.is, s.ih} = 6'(iv);
          apply(s);
        end

    // random mix
    for (int i = 0; i < 512; i++) apply(rnd_stim());

    @(negedge clk);
    wait (q.size() == 0);
    repeat (2) @(negedge clk);

    // R1: asynchronous clear mid-run
    s = '0;
    s.mode = 3'd2;
    st = s;
    repeat (2) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    n_chk++;
    if (ill_o !== '0 || virt_o !== '0 || inv2flush_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 async clear: got %h/%h/%b exp 0/0/0", ill_o, virt_o, inv2flush_o);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule